// File: doc/BRIEF.md
# Reduced 16-bit Register Execution Core

This block executes a small set of pre-decoded operations against sixteen 16-bit working registers and an external byte-addressed data memory. Each operation arrives as an opcode, an addressing mode, a byte/word select and operand fields, using a valid/ready handshake. The core runs the operation in a fixed number of clocks and writes the result to a register or to memory. It then pulses a completion strobe that reports the instruction-cycle cost, any alignment or range fault, and the updated program counter.

The supported operations are copy, add, subtract, increment, decrement and an unconditional jump. Copies can go register to register, literal to register, register to memory, memory to register, and memory to memory through addresses held in two registers. The arithmetic operations have register forms and forms that combine a memory location with register 0, the implicit accumulator. Every data operation has a word form and a byte form. A byte form touches only the low byte of a destination register, or a single byte lane of memory.

The memory port is synchronous and single-ported. Read data returns one clock after the request, and a two-bit lane enable selects the bytes written. Byte address bit 0 selects the lane: 0 is the low lane and 1 is the high lane, so words are stored little-endian.

Top module: `sx16_core`

## Requirements
- R1: After reset the program counter is 0, every working register reads 0, `in_ready` is 1, and `done`, `err_align` and `err_range` are 0.
- R2: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 until completion. `done` is high for exactly one clock per accepted operation.
- R3: The opcode is encoded as copy=0, add=1, subtract=2, increment=3, decrement=4, jump=5, and the mode as register=0, literal=1, store=2, load=3, indirect=4, file-to-memory=5, file-to-register-0=6. A copy in literal mode writes `in_imm` to register `in_rd`. A byte-form register write changes bits 7:0 only and keeps bits 15:8.
- R4: In register mode, add and subtract compute reg[`in_ra`] op reg[`in_rb`], with subtract taking `in_ra` minus `in_rb`. In literal mode, the second operand is `in_imm[4:0]` zero-extended (0..31), and the upper literal bits are ignored.
- R5: In register mode, increment and decrement write reg[`in_ra`] plus or minus 1 to `in_rd`.
- R6: In file modes the core reads memory at `in_addr`. Add and subtract combine that value with register 0 (memory minus register 0). Increment and decrement use the memory value alone. Mode 5 writes the result back to memory and mode 6 writes it to register 0.
- R7: Byte address bit 0 picks the lane (0 = bits 7:0, 1 = bits 15:8). A byte memory write asserts exactly one lane enable and leaves the other lane unchanged.
- R8: A word store writes reg[`in_ra`] to any even address, and a word load writes memory to reg[`in_rd`]. A byte store always takes its source from register 0, and a byte load always writes register 0.
- R9: Indirect mode copies the memory contents at the address held in reg[`in_ra`] to the address held in reg[`in_rd`], within one operation.
- R10: A word-form memory access at an odd address raises `err_align` with `done`. The operation then writes no register and no memory.
- R11: File modes and byte stores and loads may reach only addresses below 8192. A higher address raises `err_range` with `done`, and nothing is written. Word stores and loads have no such limit.
- R12: `icycles` reports 1 for a non-jump operation, which takes 2 clocks from acceptance to completion. It reports 2 for a jump, which takes 4 clocks.
- R13: A jump loads the program counter with `in_imm`. Every other operation, faulted or not, advances it by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Core idle and able to accept |
| in_op | input | 3 | Opcode |
| in_mode | input | 3 | Addressing mode |
| in_byte | input | 1 | 1 selects the byte form |
| in_ra | input | 4 | First source register index |
| in_rb | input | 4 | Second source register index |
| in_rd | input | 4 | Destination register index |
| in_imm | input | 16 | Literal or jump target |
| in_addr | input | 16 | Byte address for store, load and file modes |
| mem_req | output | 1 | Memory access this clock |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 15 | Word address |
| mem_be | output | 2 | Lane write enables |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one clock after the request |
| done | output | 1 | Completion strobe |
| icycles | output | 2 | Instruction cycles spent by the completed operation |
| err_align | output | 1 | Odd word address seen by the completed operation |
| err_range | output | 1 | Address beyond the near region seen by the completed operation |
| pc | output | 23 | Program counter |

## Verification
Each test issues byte and word forms of the same operation against one register or memory word. This shows whether only the low byte or the right lane changed. Subtract runs with its two sources swapped to expose operand order, and a literal above 31 shows that only five bits are used. Addresses sit at both sides of the near-region limit (0x1FFE and 0x2000), at odd addresses in word and byte form, and at a far even address with an unrestricted word store. Together these separate the range check from the alignment check, and a restricted form from an unrestricted one.

// File: rtl/sx16_pkg.sv
package sx16_pkg;
  typedef enum logic [2:0] {
    OP_MOV = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2,
    OP_INC = 3'd3, OP_DEC = 3'd4, OP_JMP = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    MD_REG = 3'd0, MD_LIT = 3'd1, MD_STORE = 3'd2, MD_LOAD = 3'd3,
    MD_IND = 3'd4, MD_FILE = 3'd5, MD_FILEW = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_EX0, S_EX1, S_JW0, S_JW1
  } state_e;
endpackage

// File: rtl/sx16_regfile.sv
module sx16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREG)-1:0]  ra_idx,
  input  logic [$clog2(NREG)-1:0]  rb_idx,
  input  logic [$clog2(NREG)-1:0]  rc_idx,
  output logic [DW-1:0]            ra_val,
  output logic [DW-1:0]            rb_val,
  output logic [DW-1:0]            rc_val,
  output logic [DW-1:0]            w0_val,
  input  logic [DW/8-1:0]          we,
  input  logic [$clog2(NREG)-1:0]  wa,
  input  logic [DW-1:0]            wd
);
  localparam int NL = DW / 8;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int l = 0; l < NL; l++)
        if (we[l]) regs[wa][l*8 +: 8] <= wd[l*8 +: 8];
    end
  end

  assign ra_val = regs[ra_idx];
  assign rb_val = regs[rb_idx];
  assign rc_val = regs[rc_idx];
  assign w0_val = regs[0];

  // R3: a low-lane-only write leaves the upper byte of that register alone
  p_byte_keeps_high_r3: assert property (@(posedge clk) disable iff (rst)
    (we != '0 && !we[NL-1]) |=> regs[$past(wa)][DW-1:DW-8] == $past(regs[wa][DW-1:DW-8]));
endmodule

// File: rtl/sx16_alu.sv
module sx16_alu #(
  parameter int DW = 16
) (
  input  sx16_pkg::op_e     op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  output logic [DW-1:0]     y
);
  import sx16_pkg::*;
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_INC:  y = a + ONE;
      OP_DEC:  y = a - ONE;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/sx16_agu.sv
module sx16_agu #(
  parameter int AW         = 16,
  parameter int LB         = 1,
  parameter int NEAR_LIMIT = 8192
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] wr_addr,
  input  logic          uses_rd,
  input  logic          uses_wr,
  input  logic          is_byte,
  input  logic          near_only,
  output logic          align_err,
  output logic          range_err
);
  localparam logic [AW:0] LIM = (AW+1)'(NEAR_LIMIT);

  logic rd_far, wr_far;
  assign rd_far = {1'b0, rd_addr} >= LIM;
  assign wr_far = {1'b0, wr_addr} >= LIM;

  assign align_err = !is_byte && ((uses_rd && |rd_addr[LB-1:0]) ||
                                  (uses_wr && |wr_addr[LB-1:0]));
  assign range_err = near_only && ((uses_rd && rd_far) || (uses_wr && wr_far));
endmodule

// File: rtl/sx16_core.sv
module sx16_core #(
  parameter int DW         = 16,
  parameter int NREG       = 16,
  parameter int AW         = 16,
  parameter int PCW        = 23,
  parameter int LITW       = 5,
  parameter int NEAR_LIMIT = 8192
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [2:0]                    in_op,
  input  logic [2:0]                    in_mode,
  input  logic                          in_byte,
  input  logic [$clog2(NREG)-1:0]       in_ra,
  input  logic [$clog2(NREG)-1:0]       in_rb,
  input  logic [$clog2(NREG)-1:0]       in_rd,
  input  logic [DW-1:0]                 in_imm,
  input  logic [AW-1:0]                 in_addr,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [AW-$clog2(DW/8)-1:0]    mem_addr,
  output logic [DW/8-1:0]               mem_be,
  output logic [DW-1:0]                 mem_wdata,
  input  logic [DW-1:0]                 mem_rdata,
  output logic                          done,
  output logic [1:0]                    icycles,
  output logic                          err_align,
  output logic                          err_range,
  output logic [PCW-1:0]                pc
);
  import sx16_pkg::*;
  localparam int RW = $clog2(NREG);
  localparam int NL = DW / 8;
  localparam int LB = $clog2(NL);

  state_e          st;
  op_e             op_q;
  mode_e           md_q;
  logic            byte_q;
  logic [RW-1:0]   ra_q, rb_q, rd_q;
  logic [DW-1:0]   imm_q;
  logic [AW-1:0]   adr_q;
  logic [2:0]      cnt;
  logic [2:0]      clk_used;

  logic [RW-1:0]   src_idx, dst_idx;
  logic [DW-1:0]   ra_val, rb_val, rc_val, w0_val;
  logic [NL-1:0]   rf_we;
  logic [AW-1:0]   rd_addr, wr_addr;
  logic            is_jmp, rd_mem, wr_mem, wr_reg, near;
  logic            agu_align, agu_range, fault;
  logic [7:0]      mem_byte;
  logic [DW-1:0]   mem_val, opa, opb, y;
  op_e             alu_op;

  // decode of the latched operation
  assign is_jmp  = (op_q == OP_JMP);
  assign rd_mem  = !is_jmp && (md_q inside {MD_LOAD, MD_IND, MD_FILE, MD_FILEW});
  assign wr_mem  = !is_jmp && (md_q inside {MD_STORE, MD_IND, MD_FILE});
  assign wr_reg  = !is_jmp && (md_q inside {MD_REG, MD_LIT, MD_LOAD, MD_FILEW});
  assign near    = !is_jmp && ((md_q inside {MD_FILE, MD_FILEW}) ||
                               (byte_q && (md_q inside {MD_STORE, MD_LOAD})));
  assign src_idx = (md_q == MD_STORE && byte_q) ? '0 : ra_q;
  assign dst_idx = (md_q == MD_FILEW || (md_q == MD_LOAD && byte_q)) ? '0 : rd_q;
  assign rd_addr = (md_q == MD_IND) ? AW'(ra_val) : adr_q;
  assign wr_addr = (md_q == MD_IND) ? AW'(rc_val) : adr_q;
  assign alu_op  = (md_q inside {MD_STORE, MD_LOAD, MD_IND}) ? OP_MOV : op_q;

  sx16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .ra_idx(src_idx), .rb_idx(rb_q), .rc_idx(rd_q),
    .ra_val(ra_val), .rb_val(rb_val), .rc_val(rc_val), .w0_val(w0_val),
    .we(rf_we), .wa(dst_idx), .wd(y)
  );

  sx16_agu #(.AW(AW), .LB(LB), .NEAR_LIMIT(NEAR_LIMIT)) u_agu (
    .rd_addr(rd_addr), .wr_addr(wr_addr), .uses_rd(rd_mem), .uses_wr(wr_mem),
    .is_byte(byte_q), .near_only(near),
    .align_err(agu_align), .range_err(agu_range)
  );
  assign fault = agu_align || agu_range;

  // little-endian lane pick from the returned word
  assign mem_byte = mem_rdata[rd_addr[LB-1:0]*8 +: 8];
  assign mem_val  = byte_q ? {{(DW-8){1'b0}}, mem_byte} : mem_rdata;

  always_comb begin
    opa = ra_val;
    opb = rb_val;
    case (md_q)
      MD_LIT: begin
        opa = (op_q == OP_MOV) ? imm_q : ra_val;
        opb = {{(DW-LITW){1'b0}}, imm_q[LITW-1:0]};
      end
      MD_LOAD, MD_IND: opa = mem_val;
      MD_FILE, MD_FILEW: begin
        opa = mem_val;
        opb = w0_val;
      end
      default: ;
    endcase
  end

  sx16_alu #(.DW(DW)) u_alu (.op(alu_op), .a(opa), .b(opb), .y(y));

  // memory port: read in the first phase, write in the second
  assign mem_we    = (st == S_EX1) && wr_mem && !fault;
  assign mem_req   = ((st == S_EX0) && rd_mem) || mem_we;
  assign mem_addr  = (st == S_EX1) ? wr_addr[AW-1:LB] : rd_addr[AW-1:LB];
  assign mem_be    = (byte_q && st == S_EX1) ? (NL'(1) << wr_addr[LB-1:0]) : '1;
  assign mem_wdata = byte_q ? {NL{y[7:0]}} : y;
  assign rf_we     = (st == S_EX1 && wr_reg && !fault) ? (byte_q ? NL'(1) : '1) : '0;
  assign in_ready  = (st == S_IDLE);
  assign clk_used  = cnt + 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      icycles   <= '0;
      err_align <= 1'b0;
      err_range <= 1'b0;
      pc        <= '0;
      cnt       <= '0;
      op_q      <= OP_MOV;
      md_q      <= MD_REG;
      byte_q    <= 1'b0;
      ra_q      <= '0;
      rb_q      <= '0;
      rd_q      <= '0;
      imm_q     <= '0;
      adr_q     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin
          op_q   <= op_e'(in_op);
          md_q   <= mode_e'(in_mode);
          byte_q <= in_byte;
          ra_q   <= in_ra;
          rb_q   <= in_rb;
          rd_q   <= in_rd;
          imm_q  <= in_imm;
          adr_q  <= in_addr;
          cnt    <= '0;
          st     <= S_EX0;
        end
        S_EX0: begin
          cnt <= clk_used;
          st  <= S_EX1;
        end
        S_EX1: begin
          cnt       <= clk_used;
          err_align <= agu_align;
          err_range <= agu_range;
          if (is_jmp) st <= S_JW0;
          else begin
            st      <= S_IDLE;
            done    <= 1'b1;
            icycles <= 2'(clk_used >> 1);
            pc      <= pc + PCW'(2);
          end
        end
        S_JW0: begin
          cnt <= clk_used;
          st  <= S_JW1;
        end
        S_JW1: begin
          st      <= S_IDLE;
          done    <= 1'b1;
          icycles <= 2'(clk_used >> 1);
          pc      <= PCW'(imm_q);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: completion strobe lasts one clock
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R2: an accepted operation closes the handshake on the next clock
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R12: reported cost follows the kind of operation
  p_icyc_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> icycles == ((op_q == OP_JMP) ? 2'd2 : 2'd1));
  // R13: sequential advance and jump target
  p_pc_step_r13: assert property (@(posedge clk) disable iff (rst)
    (done && op_q != OP_JMP) |-> pc == $past(pc) + PCW'(2));
  p_pc_jump_r13: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_JMP) |-> pc == PCW'(imm_q));
  // R10 / R11: a faulting operation never writes memory or registers
  p_no_store_on_fault_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !(agu_align || agu_range));
  p_no_regwrite_on_fault_r11: assert property (@(posedge clk) disable iff (rst)
    (rf_we != '0) |-> !(agu_align || agu_range));
  // R7: byte stores drive a single lane
  p_one_lane_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && byte_q) |-> $countones(mem_be) == 1);
endmodule

// File: tb/sx16_core_test.sv
`timescale 1ns/1ps
module sx16_core_test;
  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  md;
    logic        byt;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [3:0]  rd;
    logic [15:0] imm;
    logic [15:0] adr;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 28;
  // fields: op, mode, byte, ra, rb, rd, imm, addr, requirement tag
  localparam vec_t VEC [NV] = '{
    '{3'd0, 3'd1, 1'b0, 4'd0, 4'd0, 4'd1, 16'h1234, 16'h0000, 4'd3},  // R3 literal word
    '{3'd0, 3'd1, 1'b1, 4'd0, 4'd0, 4'd1, 16'h77AB, 16'h0000, 4'd3},  // R3 byte merge
    '{3'd0, 3'd1, 1'b0, 4'd0, 4'd0, 4'd2, 16'h0800, 16'h0000, 4'd3},
    '{3'd0, 3'd1, 1'b0, 4'd0, 4'd0, 4'd3, 16'h0900, 16'h0000, 4'd3},
    '{3'd0, 3'd2, 1'b0, 4'd1, 4'd0, 4'd0, 16'h0000, 16'h0800, 4'd8},  // R8 word store
    '{3'd0, 3'd4, 1'b0, 4'd2, 4'd0, 4'd3, 16'h0000, 16'h0000, 4'd9},  // R9 indirect
    '{3'd1, 3'd1, 1'b0, 4'd1, 4'd0, 4'd4, 16'h003F, 16'h0000, 4'd4},  // R4 literal truncated to 31
    '{3'd2, 3'd0, 1'b0, 4'd4, 4'd1, 4'd5, 16'h0000, 16'h0000, 4'd4},  // R4 a-b
    '{3'd2, 3'd0, 1'b0, 4'd1, 4'd4, 4'd6, 16'h0000, 16'h0000, 4'd4},  // R4 b-a
    '{3'd3, 3'd0, 1'b0, 4'd5, 4'd0, 4'd5, 16'h0000, 16'h0000, 4'd5},  // R5 inc
    '{3'd4, 3'd0, 1'b1, 4'd6, 4'd0, 4'd6, 16'h0000, 16'h0000, 4'd5},  // R5 dec byte
    '{3'd0, 3'd1, 1'b0, 4'd0, 4'd0, 4'd0, 16'h0005, 16'h0000, 4'd3},
    '{3'd1, 3'd5, 1'b0, 4'd0, 4'd0, 4'd0, 16'h0000, 16'h0800, 4'd6},  // R6 add to memory
    '{3'd1, 3'd6, 1'b1, 4'd0, 4'd0, 4'd0, 16'h0000, 16'h0801, 4'd6},  // R6 byte high lane to reg 0
    '{3'd3, 3'd5, 1'b1, 4'd0, 4'd0, 4'd0, 16'h0000, 16'h0801, 4'd7},  // R7 lane increment
    '{3'd0, 3'd2, 1'b0, 4'd1, 4'd0, 4'd0, 16'h0000, 16'h0803, 4'd10}, // R10 odd store
    '{3'd1, 3'd5, 1'b0, 4'd0, 4'd0, 4'd0, 16'h0000, 16'h2000, 4'd11}, // R11 out of near range
    '{3'd0, 3'd3, 1'b0, 4'd0, 4'd0, 4'd7, 16'h0000, 16'h0900, 4'd8},  // R8 word load
    '{3'd0, 3'd3, 1'b1, 4'd0, 4'd0, 4'd9, 16'h0000, 16'h0901, 4'd8},  // R8 byte load goes to reg 0
    '{3'd4, 3'd5, 1'b0, 4'd0, 4'd0, 4'd0, 16'h0000, 16'h0900, 4'd6},
    '{3'd5, 3'd0, 1'b0, 4'd0, 4'd0, 4'd0, 16'h0400, 16'h0000, 4'd13}, // R13 jump
    '{3'd0, 3'd4, 1'b1, 4'd3, 4'd0, 4'd2, 16'h0000, 16'h0000, 4'd9},  // R9 byte indirect
    '{3'd0, 3'd3, 1'b0, 4'd0, 4'd0, 4'd7, 16'h0000, 16'h0805, 4'd10}, // R10 odd load
    '{3'd0, 3'd2, 1'b1, 4'd5, 4'd0, 4'd0, 16'h0000, 16'h0803, 4'd7},  // R7 byte store from reg 0
    '{3'd1, 3'd6, 1'b0, 4'd0, 4'd0, 4'd0, 16'h0000, 16'h1FFE, 4'd11}, // R11 last legal word
    '{3'd2, 3'd6, 1'b0, 4'd0, 4'd0, 4'd0, 16'h0000, 16'h2000, 4'd11},
    '{3'd0, 3'd2, 1'b1, 4'd0, 4'd0, 4'd0, 16'h0000, 16'h2001, 4'd11},
    '{3'd0, 3'd2, 1'b0, 4'd1, 4'd0, 4'd0, 16'h0000, 16'h4000, 4'd8}   // R8 far word store allowed
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0, in_mode = '0;
  logic        in_byte = 1'b0;
  logic [3:0]  in_ra = '0, in_rb = '0, in_rd = '0;
  logic [15:0] in_imm = '0, in_addr = '0;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        done, err_align, err_range;
  logic [1:0]  icycles;
  logic [22:0] pc;

  logic [15:0] mem     [1024];
  logic [15:0] exp_mem [1024];
  logic [15:0] exp_reg [16];
  logic [22:0] exp_pc;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sx16_core uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_mode(in_mode), .in_byte(in_byte),
    .in_ra(in_ra), .in_rb(in_rb), .in_rd(in_rd), .in_imm(in_imm), .in_addr(in_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .icycles(icycles), .err_align(err_align), .err_range(err_range), .pc(pc)
  );

  // synchronous memory, one clock read latency, cleared during reset
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        if (mem_be[0]) mem[mem_addr[9:0]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr[9:0]][15:8] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= mem[mem_addr[9:0]];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int widx(input logic [15:0] a);
    return int'(a[10:1]);
  endfunction

  // reference model built from the requirements
  task automatic ref_exec(input vec_t v, output logic eal, output logic erg, output int ecyc);
    logic rdm, wrm, wrr, near;
    logic [15:0] rda, wra, mv, a, b, y, w;
    logic [3:0] src, dst;
    eal = 1'b0; erg = 1'b0;
    if (v.op == 3'd5) begin
      exp_pc = 23'(v.imm);
      ecyc = 2;
      return;
    end
    ecyc = 1;
    exp_pc = exp_pc + 23'd2;
    rdm = 1'b0; wrm = 1'b0; wrr = 1'b0; near = 1'b0;
    rda = v.adr; wra = v.adr; src = v.ra; dst = v.rd;
    case (v.md)
      3'd0, 3'd1: wrr = 1'b1;
      3'd2: begin wrm = 1'b1; near = v.byt; if (v.byt) src = 4'd0; end
      3'd3: begin rdm = 1'b1; wrr = 1'b1; near = v.byt; if (v.byt) dst = 4'd0; end
      3'd4: begin rdm = 1'b1; wrm = 1'b1; rda = exp_reg[v.ra]; wra = exp_reg[v.rd]; end
      3'd5: begin rdm = 1'b1; wrm = 1'b1; near = 1'b1; end
      3'd6: begin rdm = 1'b1; wrr = 1'b1; near = 1'b1; dst = 4'd0; end
      default: ;
    endcase
    eal = !v.byt && ((rdm && rda[0]) || (wrm && wra[0]));
    erg = near && ((rdm && rda >= 16'h2000) || (wrm && wra >= 16'h2000));
    w  = exp_mem[widx(rda)];
    mv = v.byt ? {8'h00, (rda[0] ? w[15:8] : w[7:0])} : w;
    a = exp_reg[src]; b = exp_reg[v.rb];
    if (v.md == 3'd1) begin
      b = {11'd0, v.imm[4:0]};
      if (v.op == 3'd0) a = v.imm;
    end
    if (v.md >= 3'd3) a = mv;
    if (v.md >= 3'd5) b = exp_reg[0];
    if (v.md inside {3'd2, 3'd3, 3'd4}) y = a;
    else case (v.op)
      3'd1: y = a + b;
      3'd2: y = a - b;
      3'd3: y = a + 16'd1;
      3'd4: y = a - 16'd1;
      default: y = a;
    endcase
    if (!(eal || erg)) begin
      if (wrr) begin
        if (v.byt) exp_reg[dst][7:0] = y[7:0];
        else exp_reg[dst] = y;
      end
      if (wrm) begin
        if (!v.byt) exp_mem[widx(wra)] = y;
        else if (wra[0]) exp_mem[widx(wra)][15:8] = y[7:0];
        else exp_mem[widx(wra)][7:0] = y[7:0];
      end
    end
  endtask

  task automatic run(input vec_t v);
    int n;
    int ecyc;
    int bad;
    logic eal, erg;
    string tg;
    tg = $sformatf("R%0d", v.tag);
    @(negedge clk);
    in_op = v.op; in_mode = v.md; in_byte = v.byt;
    in_ra = v.ra; in_rb = v.rb; in_rd = v.rd; in_imm = v.imm; in_addr = v.adr;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", 32'(in_ready), 32'd0, "ready while busy");
    n = 1;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    ref_exec(v, eal, erg, ecyc);
    check("R2", 32'(done), 32'd1, "completion seen");
    check("R12", 32'(icycles), 32'(ecyc), "instruction cycles");
    check("R12", 32'(n - 1), 32'(2 * ecyc), "clocks to completion");
    check("R10", 32'(err_align), 32'(eal), "alignment flag");
    check("R11", 32'(err_range), 32'(erg), "range flag");
    check("R13", 32'(pc), 32'(exp_pc), "program counter");
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) bad++;
    check(tg, 32'(bad), 32'd0, "memory words differing from model");
    @(negedge clk);
    check("R2", 32'(done), 32'd0, "single-clock completion strobe");
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 1024; i++) exp_mem[i] = '0;
    for (int i = 0; i < 16; i++) exp_reg[i] = '0;
    exp_pc = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: done=%0b expected run to finish", done);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state at the ports
    check("R1", 32'(pc), 32'd0, "pc after reset");
    check("R1", 32'(in_ready), 32'd1, "ready after reset");
    check("R1", 32'({done, err_align, err_range}), 32'd0, "strobes after reset");

    for (int k = 0; k < NV; k++) run(VEC[k]);

    // dump every register through word stores and compare with the model (R3, R8, R1)
    for (int r = 0; r < 16; r++) begin
      run('{3'd0, 3'd2, 1'b0, 4'(r), 4'd0, 4'd0, 16'h0000, 16'(16'h0A00 + 2 * r), 4'd8});
      check("R3", 32'(mem[widx(16'(16'h0A00 + 2 * r))]), 32'(exp_reg[r]),
            $sformatf("register %0d contents", r));
    end

    // reset in mid-run returns the core to its initial state (R1)
    run('{3'd5, 3'd0, 1'b0, 4'd0, 4'd0, 4'd0, 16'h0123, 16'h0000, 4'd13});
    do_reset();
    @(negedge clk);
    check("R1", 32'(pc), 32'd0, "pc after second reset");
    run('{3'd0, 3'd2, 1'b0, 4'd1, 4'd0, 4'd0, 16'h0000, 16'h0A00, 4'd1});
    check("R1", 32'(mem[widx(16'h0A00)]), 32'd0, "register 1 cleared by reset");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule